// File: doc/BRIEF.md
# Indexed Configuration Register Space with GPIO Pin Banking

This block is a byte-wide configuration register file that a host reaches through a pair of I/O ports. A write to the command port loads an index. The next read or write at the data port, one address above, then reaches the register that index names. A strap input picks which of two command-port addresses the block answers on. Accesses to any other address read as zero and change nothing.

The space holds a few global registers: a fixed identification byte and a chip configuration byte whose low bit is the global enable. It also holds one bank of registers for each logical unit, and a unit-select register chooses which bank is visible. Each implemented unit has an activate byte and a 16-bit runtime base address. The GPIO unit adds one configuration byte and one event byte per pin. These are reached through a pin-select register that packs a port number and a bit number into one byte. The block presents the GPIO runtime base, the unit-active flags and every per-pin byte as outputs, which feed the GPIO runtime bank.

Top module: `idx_cfg_space`

## Requirements
- R1: A write to the command port stores the written byte as the current index, and a read of the command port returns that index. No other access changes the index.
- R2: When altPortSel is 0, the command port is at 0x002E and the data port at 0x002F. When altPortSel is 1, they are at 0x004E and 0x004F. A read at any other address returns 0x00, and a write there changes no register.
- R3: Index 0x20 always reads 0xE9. Writes to it have no effect.
- R4: Index 0x21 is a read/write byte, and its bit 0 drives chipEn.
- R5: Index 0x07 is a read/write unit-select byte. The implemented units are 0x07 (GPIO), 0x0D and 0x0E.
- R6: Index 0x30 reads and writes the activate byte of the selected unit. unitActive bit 0, bit 1 and bit 2 belong to units 0x07, 0x0D and 0x0E, and each bit is 1 while that unit's activate byte is nonzero. While an unimplemented unit is selected, index 0x30 reads 0x00 and ignores writes.
- R7: Indices 0x60 and 0x61 read and write the high byte and the low byte of the selected unit's 16-bit base address. An unimplemented unit reads 0x00 and ignores writes. gpioBase always shows the base of unit 0x07.
- R8: Index 0xF0 is pin select. Bits 5:4 hold the port and bits 2:0 hold the bit; all other bits read back 0. The selected pin number is port*8+bit.
- R9: Index 0xF1 reads and writes the configuration byte of the selected pin, and index 0xF2 reads and writes its event byte. A read returns the stored byte, so a read-modify-write of bit 2 (pull-up) keeps the other bits. Pin n's bytes appear on pinCfgBus[8n+7:8n] and pinEvtBus[8n+7:8n].
- R10: While the selected unit is not 0x07, indices 0xF0 to 0xF2 read 0x00 and ignore writes.
- R11: After reset the index is 0x00, the unit select is 0x00, and all activate, base, chip configuration, pin select and pin bytes are 0x00.
- R12: Any index not listed above reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| altPortSel | input | 1 | Strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| ioAddr | input | 16 | Host I/O address |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe, captured on the rising clock edge |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, combinational while ioRd is high, else 0 |
| chipEn | output | 1 | Global chip enable |
| unitActive | output | 3 | Activate flags of units 0x07, 0x0D, 0x0E |
| gpioBase | output | 16 | Runtime base address of the GPIO unit |
| pinCfgBus | output | 256 | Configuration bytes of the 32 pins |
| pinEvtBus | output | 256 | Event bytes of the 32 pins |

## Verification
Every one of the 32 pins is programmed with a byte derived from its own number. Each pin-select write carries junk in the unused bits, so a wrong port/bit packing or a failure to mask shows up as a mismatch on the output buses. A pull-up read-modify-write pass then tells a correct stored readback apart from a register that loses its other bits. Each unit receives a distinct activate value and a distinct base, and an unimplemented unit number is also used, which exposes bank aliasing. Full sweeps of the unlisted indices and of the wrong-strap addresses separate correct decoding from decoding that is partial or stuck on one strap.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  localparam int NUM_UNITS = 3;

  localparam logic [7:0] IDX_UNITSEL = 8'h07;
  localparam logic [7:0] IDX_CHIPID  = 8'h20;
  localparam logic [7:0] IDX_CHIPCFG = 8'h21;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASEHI  = 8'h60;
  localparam logic [7:0] IDX_BASELO  = 8'h61;
  localparam logic [7:0] IDX_PINSEL  = 8'hF0;
  localparam logic [7:0] IDX_PINCFG  = 8'hF1;
  localparam logic [7:0] IDX_PINEVT  = 8'hF2;

  localparam logic [7:0] CHIP_ID   = 8'hE9;
  localparam logic [7:0] UNIT_GPIO = 8'h07;

  // Unit slot k -> logical unit number; slot 0 is the GPIO unit
  function automatic logic [7:0] unitNum(input int k);
    case (k)
      0:       return UNIT_GPIO;
      1:       return 8'h0D;
      default: return 8'h0E;
    endcase
  endfunction

  typedef enum logic [3:0] {
    RS_NONE, RS_CHIPID, RS_CHIPCFG, RS_UNITSEL, RS_ACT,
    RS_BASEHI, RS_BASELO, RS_PINSEL, RS_PINCFG, RS_PINEVT
  } rdSel_e;

  typedef struct packed {
    logic       wrChipCfg;
    logic       wrUnitSel;
    logic       wrAct;
    logic       wrBaseHi;
    logic       wrBaseLo;
    logic       wrPinSel;
    logic       wrPinCfg;
    logic       wrPinEvt;
    logic [7:0] wdata;
  } cfgStrobes_t;
endpackage

// File: rtl/cfgsp_ctrl.sv
module cfgsp_ctrl
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] PRI_BASE = 16'h002E,
  parameter logic [15:0] ALT_BASE = 16'h004E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        altPortSel,
  input  logic [15:0] ioAddr,
  input  logic        ioRd,
  input  logic        ioWr,
  input  logic [7:0]  ioWdata,
  input  logic        gpioSel,
  input  logic [7:0]  dataRdata,
  output cfgStrobes_t strb,
  output rdSel_e      rdSel,
  output logic [7:0]  ioRdata
);
  logic [15:0] cmdBase;
  logic [15:0] dataBase;
  logic        hitCmd;
  logic        hitData;
  logic        dataWr;
  logic [7:0]  cfgIndex;

  assign cmdBase  = altPortSel ? ALT_BASE : PRI_BASE;
  assign dataBase = 16'(cmdBase + 16'd1);
  assign hitCmd   = (ioAddr == cmdBase);
  assign hitData  = (ioAddr == dataBase);
  assign dataWr   = ioWr && hitData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgIndex <= 8'h00;
    end else if (ioWr && hitCmd) begin
      cfgIndex <= ioWdata;
    end
  end

  always_comb begin
    case (cfgIndex)
      IDX_CHIPID:  rdSel = RS_CHIPID;
      IDX_CHIPCFG: rdSel = RS_CHIPCFG;
      IDX_UNITSEL: rdSel = RS_UNITSEL;
      IDX_ACT:     rdSel = RS_ACT;
      IDX_BASEHI:  rdSel = RS_BASEHI;
      IDX_BASELO:  rdSel = RS_BASELO;
      IDX_PINSEL:  rdSel = gpioSel ? RS_PINSEL : RS_NONE;
      IDX_PINCFG:  rdSel = gpioSel ? RS_PINCFG : RS_NONE;
      IDX_PINEVT:  rdSel = gpioSel ? RS_PINEVT : RS_NONE;
      default:     rdSel = RS_NONE;
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.wdata     = ioWdata;
    strb.wrChipCfg = dataWr && (rdSel == RS_CHIPCFG);
    strb.wrUnitSel = dataWr && (rdSel == RS_UNITSEL);
    strb.wrAct     = dataWr && (rdSel == RS_ACT);
    strb.wrBaseHi  = dataWr && (rdSel == RS_BASEHI);
    strb.wrBaseLo  = dataWr && (rdSel == RS_BASELO);
    strb.wrPinSel  = dataWr && (rdSel == RS_PINSEL);
    strb.wrPinCfg  = dataWr && (rdSel == RS_PINCFG);
    strb.wrPinEvt  = dataWr && (rdSel == RS_PINEVT);
  end

  always_comb begin
    if (!ioRd)        ioRdata = 8'h00;
    else if (hitCmd)  ioRdata = cfgIndex;
    else if (hitData) ioRdata = dataRdata;
    else              ioRdata = 8'h00;
  end

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && hitCmd) |=> $stable(cfgIndex)); // R1
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && hitCmd) |=> (cfgIndex == $past(ioWdata))); // R1
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && hitData && cfgIndex == IDX_CHIPID) |-> (ioRdata == CHIP_ID)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.wrChipCfg, strb.wrUnitSel, strb.wrAct, strb.wrBaseHi,
                strb.wrBaseLo, strb.wrPinSel, strb.wrPinCfg, strb.wrPinEvt}) <= 1); // R12
endmodule

// File: rtl/cfgsp_dpath.sv
module cfgsp_dpath
  import cfgsp_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobes_t               strb,
  input  rdSel_e                    rdSel,
  output logic [7:0]                dataRdata,
  output logic                      gpioSel,
  output logic                      chipEn,
  output logic [NUM_UNITS-1:0]      unitActive,
  output logic [15:0]               gpioBase,
  output logic [NUM_PORTS*PINS_PER_PORT*8-1:0] pinCfgBus,
  output logic [NUM_PORTS*PINS_PER_PORT*8-1:0] pinEvtBus
);
  localparam int NPINS  = NUM_PORTS * PINS_PER_PORT;
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int BIT_W  = (PINS_PER_PORT > 1) ? $clog2(PINS_PER_PORT) : 1;
  localparam int PIN_W  = PORT_W + BIT_W;

  logic [7:0]                  chipCfg;
  logic [7:0]                  unitSel;
  logic [7:0]                  pinSel;
  logic [PIN_W-1:0]            pinIdx;
  logic [NUM_UNITS-1:0]        unitHit;
  logic [NUM_UNITS-1:0][7:0]   actVec;
  logic [NUM_UNITS-1:0][15:0]  baseVec;
  logic [7:0]                  selAct;
  logic [15:0]                 selBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipCfg <= 8'h00;
      unitSel <= 8'h00;
      pinSel  <= 8'h00;
    end else begin
      if (strb.wrChipCfg) chipCfg <= strb.wdata;
      if (strb.wrUnitSel) unitSel <= strb.wdata;
      if (strb.wrPinSel) begin
        pinSel              <= 8'h00;
        pinSel[4 +: PORT_W] <= strb.wdata[4 +: PORT_W];
        pinSel[0 +: BIT_W]  <= strb.wdata[0 +: BIT_W];
      end
    end
  end

  assign chipEn  = chipCfg[0];
  assign gpioSel = (unitSel == UNIT_GPIO);
  assign pinIdx  = {pinSel[4 +: PORT_W], pinSel[0 +: BIT_W]};

  for (genvar k = 0; k < NUM_UNITS; k++) begin : gen_unit
    logic [7:0]  act;
    logic [15:0] base;
    assign unitHit[k] = (unitSel == unitNum(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        act  <= 8'h00;
        base <= 16'h0000;
      end else if (unitHit[k]) begin
        if (strb.wrAct)    act        <= strb.wdata;
        if (strb.wrBaseHi) base[15:8] <= strb.wdata;
        if (strb.wrBaseLo) base[7:0]  <= strb.wdata;
      end
    end
    assign actVec[k]     = act;
    assign baseVec[k]    = base;
    assign unitActive[k] = |act;
  end

  assign gpioBase = baseVec[0];

  always_comb begin
    selAct  = 8'h00;
    selBase = 16'h0000;
    for (int k = 0; k < NUM_UNITS; k++) begin
      if (unitHit[k]) begin
        selAct  = selAct | actVec[k];
        selBase = selBase | baseVec[k];
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : gen_pin
    logic [7:0] cfgByte;
    logic [7:0] evtByte;
    logic       pinHit;
    assign pinHit = (pinIdx == PIN_W'(p));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgByte <= 8'h00;
        evtByte <= 8'h00;
      end else if (pinHit) begin
        if (strb.wrPinCfg) cfgByte <= strb.wdata;
        if (strb.wrPinEvt) evtByte <= strb.wdata;
      end
    end
    assign pinCfgBus[p*8 +: 8] = cfgByte;
    assign pinEvtBus[p*8 +: 8] = evtByte;
  end

  always_comb begin
    case (rdSel)
      RS_CHIPID:  dataRdata = CHIP_ID;
      RS_CHIPCFG: dataRdata = chipCfg;
      RS_UNITSEL: dataRdata = unitSel;
      RS_ACT:     dataRdata = selAct;
      RS_BASEHI:  dataRdata = selBase[15:8];
      RS_BASELO:  dataRdata = selBase[7:0];
      RS_PINSEL:  dataRdata = pinSel;
      RS_PINCFG:  dataRdata = pinCfgBus[pinIdx*8 +: 8];
      RS_PINEVT:  dataRdata = pinEvtBus[pinIdx*8 +: 8];
      default:    dataRdata = 8'h00;
    endcase
  end

  AST_UNIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(unitHit)); // R5
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPinSel || strb.wrPinCfg || strb.wrPinEvt) |-> gpioSel); // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPinCfg |=> $stable(pinCfgBus)); // R9
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrAct |=> $stable(unitActive)); // R6
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrBaseHi && !strb.wrBaseLo |=> $stable(gpioBase)); // R7
endmodule

// File: rtl/idx_cfg_space.sv
module idx_cfg_space
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] PRI_BASE      = 16'h002E,
  parameter logic [15:0] ALT_BASE      = 16'h004E,
  parameter int          NUM_PORTS     = 4,
  parameter int          PINS_PER_PORT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        altPortSel,
  input  logic [15:0] ioAddr,
  input  logic        ioRd,
  input  logic        ioWr,
  input  logic [7:0]  ioWdata,
  output logic [7:0]  ioRdata,
  output logic        chipEn,
  output logic [2:0]  unitActive,
  output logic [15:0] gpioBase,
  output logic [NUM_PORTS*PINS_PER_PORT*8-1:0] pinCfgBus,
  output logic [NUM_PORTS*PINS_PER_PORT*8-1:0] pinEvtBus
);
  cfgStrobes_t strb;
  rdSel_e      rdSel;
  logic [7:0]  dataRdata;
  logic        gpioSel;

  cfgsp_ctrl #(.PRI_BASE(PRI_BASE), .ALT_BASE(ALT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .altPortSel(altPortSel),
    .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr), .ioWdata(ioWdata),
    .gpioSel(gpioSel), .dataRdata(dataRdata),
    .strb(strb), .rdSel(rdSel), .ioRdata(ioRdata)
  );

  cfgsp_dpath #(.NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .dataRdata(dataRdata), .gpioSel(gpioSel), .chipEn(chipEn),
    .unitActive(unitActive), .gpioBase(gpioBase),
    .pinCfgBus(pinCfgBus), .pinEvtBus(pinEvtBus)
  );
endmodule

// File: tb/idx_cfg_space_bench.sv
module idx_cfg_space_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        altPortSel = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic        ioRd = 1'b0;
  logic        ioWr = 1'b0;
  logic [7:0]  ioWdata = 8'h00;
  logic [7:0]  ioRdata;
  logic        chipEn;
  logic [2:0]  unitActive;
  logic [15:0] gpioBase;
  logic [NPINS*8-1:0] pinCfgBus;
  logic [NPINS*8-1:0] pinEvtBus;

  int checks = 0;
  int fails = 0;
  logic [7:0] expCfg [NPINS];
  logic [7:0] expEvt [NPINS];

  idx_cfg_space u_idx_cfg_space (
    .clk(clk), .rstN(rstN), .altPortSel(altPortSel), .ioAddr(ioAddr),
    .ioRd(ioRd), .ioWr(ioWr), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .chipEn(chipEn), .unitActive(unitActive), .gpioBase(gpioBase),
    .pinCfgBus(pinCfgBus), .pinEvtBus(pinEvtBus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] cmdPort();
    return altPortSel ? 16'h004E : 16'h002E;
  endfunction

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1 d = ioRdata;
    ioRd = 1'b0;
  endtask

  task automatic cfgWrite(input logic [7:0] idx, input logic [7:0] d);
    ioWrite(cmdPort(), idx);
    ioWrite(16'(cmdPort() + 16'd1), d);
  endtask

  task automatic cfgRead(input logic [7:0] idx, output logic [7:0] d);
    ioWrite(cmdPort(), idx);
    ioRead(16'(cmdPort() + 16'd1), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] units [4];
    units[0] = 8'h07; units[1] = 8'h0D; units[2] = 8'h0E; units[3] = 8'h03;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    ioRead(16'h002E, d);      check("R11 index", d, 8'h00);
    cfgRead(8'h07, d);        check("R11 unitsel", d, 8'h00);
    cfgRead(8'h21, d);        check("R11 chipcfg", d, 8'h00);
    check("R11 chipEn", chipEn, 0);
    check("R11 unitActive", unitActive, 0);
    check("R11 gpioBase", gpioBase, 0);
    check("R11 pinCfgBus", pinCfgBus, 0);
    check("R11 pinEvtBus", pinEvtBus, 0);

    // R1 index latch and readback
    ioWrite(16'h002E, 8'h5A); ioRead(16'h002E, d); check("R1 index", d, 8'h5A);

    // R3 chip id, write ignored
    cfgWrite(8'h20, 8'h00); cfgRead(8'h20, d); check("R3 id", d, 8'hE9);

    // R4 chip config
    cfgWrite(8'h21, 8'hA5); cfgRead(8'h21, d); check("R4 rd", d, 8'hA5);
    check("R4 chipEn1", chipEn, 1);
    cfgWrite(8'h21, 8'h02); check("R4 chipEn0", chipEn, 0);

    // R2 strap: alternate port, old ports dead
    altPortSel = 1'b1;
    cfgRead(8'h20, d); check("R2 alt id", d, 8'hE9);
    ioWrite(16'h002E, 8'h21); ioWrite(16'h002F, 8'hFF);
    cfgRead(8'h21, d); check("R2 stray write", d, 8'h02);
    ioRead(16'h002F, d); check("R2 stray read", d, 8'h00);
    for (int a = 16'h0040; a < 16'h0060; a++) begin
      if (a != 16'h004E && a != 16'h004F) begin
        ioRead(16'(a), d); check("R2 other addr", d, 8'h00);
      end
    end
    ioRead(16'h004E, d); check("R2 alt index", d, 8'h21);
    altPortSel = 1'b0;
    cfgRead(8'h21, d); check("R2 primary", d, 8'h02);

    // R5 R6 R7 units
    for (int k = 0; k < 4; k++) begin
      cfgWrite(8'h07, units[k]);
      cfgRead(8'h07, d); check("R5 unitsel", d, units[k]);
      cfgWrite(8'h30, 8'(k + 1));
      cfgWrite(8'h60, 8'(8'h10 * (k + 1)));
      cfgWrite(8'h61, 8'(8'h0F - k));
    end
    for (int k = 0; k < 4; k++) begin
      cfgWrite(8'h07, units[k]);
      cfgRead(8'h30, d); check("R6 act", d, (k < 3) ? 8'(k + 1) : 8'h00);
      cfgRead(8'h60, d); check("R7 hi", d, (k < 3) ? 8'(8'h10 * (k + 1)) : 8'h00);
      cfgRead(8'h61, d); check("R7 lo", d, (k < 3) ? 8'(8'h0F - k) : 8'h00);
    end
    check("R6 unitActive", unitActive, 3'b111);
    check("R7 gpioBase", gpioBase, 16'h100F);
    cfgWrite(8'h07, 8'h0D); cfgWrite(8'h30, 8'h00);
    check("R6 deact", unitActive, 3'b101);

    // R8 R9 pins in GPIO unit
    cfgWrite(8'h07, 8'h07);
    for (int p = 0; p < NPINS; p++) begin
      logic [7:0] sel;
      sel = 8'(((p / 8) << 4) | (p % 8));
      cfgWrite(8'hF0, sel | 8'hC8);
      cfgRead(8'hF0, d); check("R8 pinsel", d, sel);
      expCfg[p] = 8'(p * 5 + 1) & 8'hFB;
      expEvt[p] = ~8'(p);
      cfgWrite(8'hF1, expCfg[p]);
      cfgWrite(8'hF2, expEvt[p]);
    end
    for (int p = 0; p < NPINS; p++) begin
      check("R9 cfgbus", pinCfgBus[p*8 +: 8], expCfg[p]);
      check("R9 evtbus", pinEvtBus[p*8 +: 8], expEvt[p]);
    end
    for (int p = 0; p < NPINS; p++) begin
      cfgWrite(8'hF0, 8'(((p / 8) << 4) | (p % 8)));
      cfgRead(8'hF1, d); check("R9 cfg rd", d, expCfg[p]);
      cfgWrite(8'hF1, d | 8'h04);
      expCfg[p] = expCfg[p] | 8'h04;
      cfgRead(8'hF2, d); check("R9 evt rd", d, expEvt[p]);
    end
    for (int p = 0; p < NPINS; p++)
      check("R9 pullup", pinCfgBus[p*8 +: 8], expCfg[p]);

    // R10 gating under another unit (last pin 31 selected)
    cfgWrite(8'h07, 8'h0E);
    cfgRead(8'hF0, d); check("R10 sel rd", d, 8'h00);
    cfgRead(8'hF1, d); check("R10 cfg rd", d, 8'h00);
    cfgRead(8'hF2, d); check("R10 evt rd", d, 8'h00);
    cfgWrite(8'hF1, 8'hFF); cfgWrite(8'hF2, 8'hFF); cfgWrite(8'hF0, 8'h00);
    check("R10 cfgbus", pinCfgBus[31*8 +: 8], expCfg[31]);
    check("R10 evtbus", pinEvtBus[31*8 +: 8], expEvt[31]);
    cfgWrite(8'h07, 8'h07);
    cfgRead(8'hF0, d); check("R10 sel kept", d, 8'h37);

    // R12 unlisted indices
    for (int i = 0; i < 256; i++) begin
      if (!(i inside {8'h07, 8'h20, 8'h21, 8'h30, 8'h60, 8'h61, 8'hF0, 8'hF1, 8'hF2})) begin
        cfgWrite(8'(i), 8'hFF);
        cfgRead(8'(i), d); check("R12 unlisted", d, 8'h00);
      end
    end
    check("R12 cfg intact", pinCfgBus, {expCfg[31], expCfg[30], expCfg[29], expCfg[28],
      expCfg[27], expCfg[26], expCfg[25], expCfg[24], expCfg[23], expCfg[22], expCfg[21],
      expCfg[20], expCfg[19], expCfg[18], expCfg[17], expCfg[16], expCfg[15], expCfg[14],
      expCfg[13], expCfg[12], expCfg[11], expCfg[10], expCfg[9], expCfg[8], expCfg[7],
      expCfg[6], expCfg[5], expCfg[4], expCfg[3], expCfg[2], expCfg[1], expCfg[0]});
    check("R12 unitActive", unitActive, 3'b101);
    check("R12 chipEn", chipEn, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule